// File: doc/BRIEF.md
# PHY Test-Port Configuration Loader

This block sits behind two host-writable words and turns them into writes to an internal 256-entry, 8-bit PHY configuration register file. The host first writes a 32-bit command word, then toggles a two-bit strobe register. A falling edge on strobe bit 1 commits one phase. If bit 16 of the held command word is set, the low byte of that word becomes the target index. If bit 16 is clear, the low byte is written into the entry at the index latched earlier. A falling edge on strobe bit 0 clears the whole file back to its defaults.

The latched index is sticky: it stays until the next index phase or a clear, so repeated value phases rewrite the same entry. A value phase with no index latched since reset or the last clear is dropped. Downstream logic can read any entry through a combinational read port. Three PLL configuration entries are also unpacked into named fields on dedicated outputs.

Top module: `phy_tif_loader`

## Requirements
- R1: After reset every entry reads 0x00, except entry 0x24, which reads 0xA0. No index is latched.
- R2: A strobe bit 1 fall while the held word has bit 16 set latches word bits 7:0 as the index. It changes no entry.
- R3: A strobe bit 1 fall while the held word has bit 16 clear writes word bits 7:0 into the latched entry. The new value shows on `rd_data` from the clock edge that accepts the strobe-low write. Word bits 31:17 and 15:8 are ignored.
- R4: A value phase that arrives while no index is latched writes no entry.
- R5: The latched index is kept across value phases, so a second value phase overwrites the same entry and leaves other entries unchanged.
- R6: Phases are committed only on a 1-to-0 transition of strobe bit 1. Strobe writes of 0 after 0, 1 after 0, or 1 after 1 on that bit commit nothing. Likewise, a rise of bit 0 alone clears nothing.
- R7: A 1-to-0 transition of strobe bit 0 restores every entry to its R1 default and forgets the latched index.
- R8: Entry 0x20 is unpacked as follows: bit 5 to `pll_div5f`, bit 4 to `pll_div1f`, bits 3:1 to `pll_fbd2p`, and bit 0 to `pll_bw_en`.
- R9: Entry 0x23 is unpacked as follows: bit 7 to `pll_prediv1p` and bits 6:0 to `pll_prediv`.
- R10: Entry 0x24 holds a fixed field at bits 7:5 (default 5). It is unpacked as follows: bit 4 to `pll_vco_sel`, bits 3:2 to `pll_lpf_rs`, and bits 1:0 to `pll_lpf_cs`.
- R11: When one strobe write makes both bits fall together, the clear wins and no entry is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_we | input | 1 | Load the command word register |
| word_wdata | input | 32 | Command word: bit 16 marks an index phase, bits 7:0 carry index or value |
| strb_we | input | 1 | Load the strobe register |
| strb_wdata | input | 2 | Strobe value: bit 1 commits a phase on its fall, bit 0 clears on its fall |
| rd_addr | input | 8 | Read index |
| rd_data | output | 8 | Entry at `rd_addr` |
| pll_div5f | output | 1 | Entry 0x20 bit 5 |
| pll_div1f | output | 1 | Entry 0x20 bit 4 |
| pll_fbd2p | output | 3 | Entry 0x20 bits 3:1 |
| pll_bw_en | output | 1 | Entry 0x20 bit 0 |
| pll_prediv1p | output | 1 | Entry 0x23 bit 7 |
| pll_prediv | output | 7 | Entry 0x23 bits 6:0 |
| pll_vco_sel | output | 1 | Entry 0x24 bit 4 |
| pll_lpf_rs | output | 2 | Entry 0x24 bits 3:2 |
| pll_lpf_cs | output | 2 | Entry 0x24 bits 1:0 |

## Verification
The hardest cases to reach are the strobe writes that must commit nothing: a value phase with no index latched, and a single strobe write that drops both bits at once. A well-behaved host sequence never produces them. The stimulus therefore writes the strobe register directly with chosen bit patterns, outside the normal two-write phase routine. It repeats high and low values, raises bit 0 alone, and writes 0b11 followed by 0b00. After each such write it reads back the entry that could have been touched.

// File: rtl/tif_pkg.sv
package tif_pkg;

    localparam int unsigned TIF_DW       = 8;
    localparam logic [2:0]  PLLV_FIXED   = 3'd5;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_INDEX = 2'd1,
        ACT_VALUE = 2'd2,
        ACT_CLEAR = 2'd3
    } tif_act_e;

    typedef struct packed {
        logic              phase_flag;
        logic [TIF_DW-1:0] low;
    } tif_word_t;

    typedef struct packed {
        logic [1:0] spare;
        logic       div5f;
        logic       div1f;
        logic [2:0] fbd2p;
        logic       bw_en;
    } pll_cfg1_t;

    typedef struct packed {
        logic       prediv1p;
        logic [6:0] prediv;
    } pll_cfg4_t;

    typedef struct packed {
        logic [2:0] fixed;
        logic       vco_sel;
        logic [1:0] lpf_rs;
        logic [1:0] lpf_cs;
    } pll_cfg5_t;

    function automatic logic [TIF_DW-1:0] reg_default(input int unsigned idx,
                                                       input int unsigned pllv_idx);
        pll_cfg5_t d;
        d = '0;
        d.fixed = PLLV_FIXED;
        return (idx == pllv_idx) ? d : '0;
    endfunction

endpackage

// File: rtl/tif_strobe_edge.sv
module tif_strobe_edge #(
    parameter int unsigned STRB_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strb_we,
    input  logic [STRB_W-1:0] strb_wdata,
    output logic [STRB_W-1:0] fall_vec
);
    logic [STRB_W-1:0] strobe_q;

    always_ff @(posedge clk) begin
        if (rst)
            strobe_q <= '0;
        else if (strb_we)
            strobe_q <= strb_wdata;
    end

    for (genvar b = 0; b < STRB_W; b++) begin : g_fall
        assign fall_vec[b] = strb_we & strobe_q[b] & ~strb_wdata[b];
    end

    AST_COMMIT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe_q[1]) |-> $past(fall_vec[1])) else $error("commit edge"); // R6

    AST_CLEAR_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        fall_vec[0] |=> !strobe_q[0]) else $error("clear edge"); // R7

endmodule

// File: rtl/tif_phase_decode.sv
module tif_phase_decode
    import tif_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_fall,
    input  logic              clr_fall,
    input  tif_word_t         word,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [TIF_DW-1:0] wr_data,
    output logic              clr
);
    tif_act_e          act;
    logic [ADDR_W-1:0] addr_q;
    logic              addr_vld;

    always_comb begin
        if (clr_fall)
            act = ACT_CLEAR;
        else if (cmd_fall)
            act = word.phase_flag ? ACT_INDEX : ACT_VALUE;
        else
            act = ACT_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst || act == ACT_CLEAR) begin
            addr_q   <= '0;
            addr_vld <= 1'b0;
        end else if (act == ACT_INDEX) begin
            addr_q   <= word.low[ADDR_W-1:0];
            addr_vld <= 1'b1;
        end
    end

    assign wr_en   = (act == ACT_VALUE) && addr_vld;
    assign wr_addr = addr_q;
    assign wr_data = word.low;
    assign clr     = (act == ACT_CLEAR);

    AST_INDEX_STICKY: assert property (@(posedge clk) disable iff (rst)
        (act != ACT_INDEX && act != ACT_CLEAR) |=> $stable(addr_q)) else $error("index moved"); // R5

    AST_CLEAR_FORGETS: assert property (@(posedge clk) disable iff (rst)
        clr_fall |=> !addr_vld) else $error("index kept over clear"); // R7

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        clr_fall |-> !wr_en) else $error("write during clear"); // R11

    AST_INDEX_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cmd_fall && word.phase_flag) |-> !wr_en) else $error("index phase wrote"); // R2

endmodule

// File: rtl/tif_regfile.sv
module tif_regfile
    import tif_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned PLLV_IDX = 36,
    parameter int unsigned N_TAP    = 3,
    parameter int unsigned TAP_IDX [N_TAP] = '{32, 35, 36}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [TIF_DW-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [TIF_DW-1:0] rdata,
    output logic [TIF_DW-1:0] tap [N_TAP]
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [TIF_DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= reg_default(unsigned'(i), PLLV_IDX);
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    for (genvar t = 0; t < N_TAP; t++) begin : g_tap
        assign tap[t] = mem[ADDR_W'(TAP_IDX[t])];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (we && !clr) |=> (mem[$past(waddr)] == $past(wdata))) else $error("write lost"); // R3

    AST_CLEAR_DEFAULT: assert property (@(posedge clk) disable iff (rst)
        clr |=> (mem[ADDR_W'(PLLV_IDX)] == reg_default(PLLV_IDX, PLLV_IDX))) else $error("default lost"); // R7

endmodule

// File: rtl/tif_field_view.sv
module tif_field_view
    import tif_pkg::*;
(
    input  logic [TIF_DW-1:0] raw1,
    input  logic [TIF_DW-1:0] raw4,
    input  logic [TIF_DW-1:0] raw5,
    output pll_cfg1_t         cfg1,
    output pll_cfg4_t         cfg4,
    output pll_cfg5_t         cfg5
);
    assign cfg1 = pll_cfg1_t'(raw1);
    assign cfg4 = pll_cfg4_t'(raw4);
    assign cfg5 = pll_cfg5_t'(raw5);
endmodule

// File: rtl/phy_tif_loader.sv
module phy_tif_loader
    import tif_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned FLAG_BIT = 16,
    parameter int unsigned PLL1_IDX = 32,
    parameter int unsigned PLL4_IDX = 35,
    parameter int unsigned PLL5_IDX = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_we,
    input  logic [31:0]       word_wdata,
    input  logic              strb_we,
    input  logic [1:0]        strb_wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              pll_div5f,
    output logic              pll_div1f,
    output logic [2:0]        pll_fbd2p,
    output logic              pll_bw_en,
    output logic              pll_prediv1p,
    output logic [6:0]        pll_prediv,
    output logic              pll_vco_sel,
    output logic [1:0]        pll_lpf_rs,
    output logic [1:0]        pll_lpf_cs
);
    tif_word_t         word_q;
    logic [1:0]        fall_vec;
    logic              wr_en;
    logic              clr;
    logic [ADDR_W-1:0] wr_addr;
    logic [TIF_DW-1:0] wr_data;
    logic [TIF_DW-1:0] tap [3];
    pll_cfg1_t         cfg1;
    pll_cfg4_t         cfg4;
    pll_cfg5_t         cfg5;
    logic              unused_bits;

    always_ff @(posedge clk) begin
        if (rst)
            word_q <= '0;
        else if (word_we)
            word_q <= '{phase_flag: word_wdata[FLAG_BIT], low: word_wdata[TIF_DW-1:0]};
    end

    assign unused_bits = ^{word_wdata[31:FLAG_BIT+1], word_wdata[FLAG_BIT-1:TIF_DW],
                           cfg1.spare, cfg5.fixed};

    tif_strobe_edge #(.STRB_W(2)) u_edge (
        .clk        (clk),
        .rst        (rst),
        .strb_we    (strb_we),
        .strb_wdata (strb_wdata),
        .fall_vec   (fall_vec)
    );

    tif_phase_decode #(.ADDR_W(ADDR_W)) u_decode (
        .clk      (clk),
        .rst      (rst),
        .cmd_fall (fall_vec[1]),
        .clr_fall (fall_vec[0]),
        .word     (word_q),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .clr      (clr)
    );

    tif_regfile #(
        .ADDR_W   (ADDR_W),
        .PLLV_IDX (PLL5_IDX),
        .N_TAP    (3),
        .TAP_IDX  ('{PLL1_IDX, PLL4_IDX, PLL5_IDX})
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_data),
        .tap   (tap)
    );

    tif_field_view u_view (
        .raw1 (tap[0]),
        .raw4 (tap[1]),
        .raw5 (tap[2]),
        .cfg1 (cfg1),
        .cfg4 (cfg4),
        .cfg5 (cfg5)
    );

    assign pll_div5f    = cfg1.div5f;
    assign pll_div1f    = cfg1.div1f;
    assign pll_fbd2p    = cfg1.fbd2p;
    assign pll_bw_en    = cfg1.bw_en;
    assign pll_prediv1p = cfg4.prediv1p;
    assign pll_prediv   = cfg4.prediv;
    assign pll_vco_sel  = cfg5.vco_sel;
    assign pll_lpf_rs   = cfg5.lpf_rs;
    assign pll_lpf_cs   = cfg5.lpf_cs;

    AST_NO_WRITE_ON_QUIET_STROBE: assert property (@(posedge clk) disable iff (rst)
        !strb_we |-> !wr_en) else $error("write without strobe"); // R6

endmodule

// File: tb/tb_phy_tif_loader.sv
module tb_phy_tif_loader;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        word_we = 1'b0;
    logic [31:0] word_wdata = '0;
    logic        strb_we = 1'b0;
    logic [1:0]  strb_wdata = '0;
    logic [7:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        pll_div5f, pll_div1f, pll_bw_en, pll_prediv1p, pll_vco_sel;
    logic [2:0]  pll_fbd2p;
    logic [6:0]  pll_prediv;
    logic [1:0]  pll_lpf_rs, pll_lpf_cs;

    int tests = 0;
    int fails = 0;

    int    q_addr [$];
    int    q_exp  [$];
    string q_tag  [$];

    always #10 clk = ~clk;

    phy_tif_loader dut (
        .clk(clk), .rst(rst), .word_we(word_we), .word_wdata(word_wdata),
        .strb_we(strb_we), .strb_wdata(strb_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
        .pll_div5f(pll_div5f), .pll_div1f(pll_div1f), .pll_fbd2p(pll_fbd2p),
        .pll_bw_en(pll_bw_en), .pll_prediv1p(pll_prediv1p), .pll_prediv(pll_prediv),
        .pll_vco_sel(pll_vco_sel), .pll_lpf_rs(pll_lpf_rs), .pll_lpf_cs(pll_lpf_cs)
    );

    // monitor: pops expected entries and compares the read port
    initial begin
        forever begin
            @(negedge clk);
            if (q_addr.size() > 0) begin
                int    a;
                int    e;
                string t;
                a = q_addr.pop_front();
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                rd_addr = a[7:0];
                #2;
                tests++;
                if (rd_data !== e[7:0]) begin
                    fails++;
                    $display("FAIL %s entry 0x%02h: actual 0x%02h expected 0x%02h", t, a, rd_data, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic wr_word(input logic [31:0] v);
        @(negedge clk); word_we = 1'b1; word_wdata = v;
        @(negedge clk); word_we = 1'b0;
    endtask

    task automatic wr_strb(input logic [1:0] v);
        @(negedge clk); strb_we = 1'b1; strb_wdata = v;
        @(negedge clk); strb_we = 1'b0;
    endtask

    task automatic phase(input logic [31:0] w);
        wr_word(w);
        wr_strb(2'b10);
        wr_strb(2'b00);
    endtask

    task automatic set_index(input logic [7:0] a);
        phase({15'h5A5A, 1'b1, 8'hC3, a});
    endtask

    task automatic put_value(input logic [7:0] d);
        phase({15'h7FFF, 1'b0, 8'hFF, d});
    endtask

    task automatic do_clear();
        wr_strb(2'b00);
        wr_strb(2'b01);
        wr_strb(2'b00);
    endtask

    task automatic expect_entry(input int a, input int e, input string t);
        q_addr.push_back(a);
        q_exp.push_back(e);
        q_tag.push_back(t);
        while (q_addr.size() != 0) @(negedge clk);
        #5;
    endtask

    task automatic chk(input int act, input int exp, input string t);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", t, act, exp);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        expect_entry(8'h00, 8'h00, "R1 reset zero");
        expect_entry(8'h24, 8'hA0, "R1 reset pllv default");
        chk(pll_vco_sel, 0, "R1 reset vco_sel");

        // R4 value phase with no index latched
        put_value(8'h55);
        expect_entry(8'h00, 8'h00, "R4 orphan value entry0");
        expect_entry(8'hFF, 8'h00, "R4 orphan value entryFF");

        // R2 index phase writes nothing
        set_index(8'h10);
        expect_entry(8'h10, 8'h00, "R2 index phase no write");

        // R3 value phase, upper word bits ignored
        put_value(8'h77);
        expect_entry(8'h10, 8'h77, "R3 value lands");

        // R5 sticky index
        put_value(8'h3C);
        expect_entry(8'h10, 8'h3C, "R5 rewrite same entry");
        expect_entry(8'h11, 8'h00, "R5 neighbour untouched");

        // R6 no commit without a fall of bit 1
        wr_word({16'h0000, 8'h00, 8'h99});
        wr_strb(2'b00);
        wr_strb(2'b00);
        wr_strb(2'b10);
        wr_strb(2'b10);
        expect_entry(8'h10, 8'h3C, "R6 no fall no write");
        wr_strb(2'b00);
        expect_entry(8'h10, 8'h99, "R6 fall commits");

        // R8 pll-I fields: 0x3B -> div5f 1, div1f 1, fbd2p 5, bw 1
        set_index(8'h20);
        put_value(8'h3B);
        chk(pll_div5f, 1, "R8 div5f");
        chk(pll_div1f, 1, "R8 div1f");
        chk(pll_fbd2p, 5, "R8 fbd2p");
        chk(pll_bw_en, 1, "R8 bw_en");
        put_value(8'h0C);
        chk({pll_div5f, pll_div1f, pll_fbd2p, pll_bw_en}, 6'b00_110_0, "R8 second pattern");

        // R9 pll-IV fields: 0x85 -> prediv1p 1, prediv 5
        set_index(8'h23);
        put_value(8'h85);
        chk(pll_prediv1p, 1, "R9 prediv1p");
        chk(pll_prediv, 5, "R9 prediv");

        // R10 pll-V fields
        set_index(8'h24);
        put_value(8'hAE);
        chk(pll_vco_sel, 0, "R10 vco_sel a");
        chk(pll_lpf_rs, 3, "R10 lpf_rs a");
        chk(pll_lpf_cs, 2, "R10 lpf_cs a");
        put_value(8'hB5);
        chk(pll_vco_sel, 1, "R10 vco_sel b");
        chk(pll_lpf_rs, 1, "R10 lpf_rs b");
        chk(pll_lpf_cs, 1, "R10 lpf_cs b");

        // R6 rise of bit 0 alone does not clear; R7 the fall does
        wr_strb(2'b01);
        expect_entry(8'h10, 8'h99, "R6 clear rise no effect");
        wr_strb(2'b00);
        expect_entry(8'h10, 8'h00, "R7 clear entry");
        expect_entry(8'h24, 8'hA0, "R7 clear pllv default");
        chk(pll_prediv, 0, "R7 clear prediv");
        put_value(8'h44);
        expect_entry(8'h24, 8'hA0, "R7 index forgotten");
        expect_entry(8'h00, 8'h00, "R7 index forgotten entry0");

        // R11 both bits fall together: clear wins
        set_index(8'h30);
        put_value(8'h12);
        expect_entry(8'h30, 8'h12, "R11 setup");
        wr_word({16'h0000, 8'h00, 8'h5A});
        wr_strb(2'b11);
        wr_strb(2'b00);
        expect_entry(8'h30, 8'h00, "R11 clear wins");
        do_clear();
        put_value(8'h5A);
        expect_entry(8'h30, 8'h00, "R11 no later write");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule